// File: doc/BRIEF.md
# Standby Power-Down Mode Controller

This controller moves a small processor subsystem between three operating states: normal run, a light sleep that stops only the CPU clock, and a deep standby that stops every clock in the subsystem. The CPU asks for a low-power state with a one-cycle sleep strobe. Two standby enable bits, held in two separate control registers, pick between light sleep and deep standby. A bus-held line and a DMA-busy flag can veto the deep standby. A vector of wake-up interrupt lines brings the subsystem back.

The entry rules are fixed. If either enable bit is clear, the strobe gives light sleep. If both bits are set, the strobe gives deep standby, provided the bus is held locally and no DMA transfer is running. Otherwise the request is refused and a one-cycle flag reports the refusal. On entry to deep standby, a one-cycle partial-reset pulse clears the chosen peripheral registers, and the settling counter is stopped and zeroed. CPU registers and RAM are outside this block and keep their contents.

On wake from deep standby, the controller captures a 3-bit clock-select value. It then runs the settling counter from zero at the selected prescaler rate and keeps every clock stopped until the counter overflows. The oscillator, PLL, CPU, RAM and interrupt controller are not part of this block. Only the clock-enable and reset outputs reach them.

Top module: `pwrdn_ctrl`

## Requirements
- R1: A sleep strobe taken in run mode with both enable bits at 1, busHeldN at 1 and dmaBusy at 0 moves the block to deep standby (mode 2) on the next clock edge.
- R2: A sleep strobe taken in run mode with either enable bit at 0 moves the block to light sleep (mode 1), whatever the bus and DMA inputs are. In light sleep cpuClkEn is 0 and perClkEn is 1. Any wake line at 1 returns the block to run (mode 0) on the next edge.
- R3: A deep-standby request (both enable bits at 1) taken while busHeldN is 0 leaves the block in run mode. refused is then 1 for exactly the one cycle after that edge.
- R4: A deep-standby request taken while dmaBusy is 1 leaves the block in run mode. refused is then 1 for exactly one cycle.
- R5: In deep standby (mode 2), cpuClkEn and perClkEn are both 0.
- R6: perRstPulse is 1 for exactly the first cycle of deep standby and is 0 at every other time.
- R7: A wake line at 1 in deep standby moves the block to settling (mode 3) and captures clkSel = n. Settling lasts exactly 2^(n+1) * 2^CNT_W cycles with both clock enables at 0. The block then returns to run.
- R8: A sleep strobe taken outside run mode is ignored. Wake lines are ignored in run mode and during settling.
- R9: The mode output encodes run=0, light sleep=1, deep standby=2, settling=3. In run mode both clock enables are 1.
- R10: After reset the block is in run mode with both clock enables at 1 and perRstPulse and refused at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | One-cycle sleep strobe from the CPU |
| stbyEnA | input | 1 | Standby enable bit from the first control register |
| stbyEnB | input | 1 | Standby enable bit from the second control register |
| busHeldN | input | 1 | Low while the bus is released to an external master |
| dmaBusy | input | 1 | High while the transfer controller is active |
| wakeIrq | input | IRQ_W | Wake-up interrupt lines |
| clkSel | input | 3 | Prescaler select; the divide ratio is 2^(clkSel+1) |
| cpuClkEn | output | 1 | CPU clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| perRstPulse | output | 1 | One-cycle partial reset of peripherals on standby entry |
| refused | output | 1 | One-cycle flag for a refused standby request |
| mode | output | 2 | Current operating mode |

## Verification
The checker tests on every cycle that the clock enables match the mode (R5, R9, and the light-sleep and settling parts of R2 and R7). It also tests that the partial-reset pulse lasts one cycle and appears only when run hands over to standby, that a refusal always leaves the block in run, and that standby leads only to standby or settling. Some behaviours depend on the stimulus and the elapsed time, so only the bench's scenarios can show them. These are the exact settling length for each prescaler select, the choice between sleep, standby and refusal for each combination of enable bits, bus and DMA, and the strobes and wakes that must be ignored.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  localparam int PD_SEL_W = 3;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_SLEEP  = 2'd1,
    MODE_STBY   = 2'd2,
    MODE_SETTLE = 2'd3
  } pdMode_e;

  // strobes from control to the settling datapath
  typedef struct packed {
    logic                clear;  // zero prescaler/counter, capture select
    logic                run;    // advance the settling count
    logic [PD_SEL_W-1:0] sel;    // select value to capture on clear
  } pdStrobe_t;
endpackage

// File: rtl/pwrdn_settle.sv
module pwrdn_settle
  import pwrdn_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  pdStrobe_t strb,
  output logic      ovf
);
  localparam int PRE_W = 1 << PD_SEL_W;
  localparam logic [PD_SEL_W-1:0] TOP_SEL = PD_SEL_W'(PRE_W - 1);
  localparam logic [PRE_W-1:0] PRE_ONES = '1;

  logic [PD_SEL_W-1:0] selQ;
  logic [PRE_W-1:0]    preQ;
  logic [PRE_W-1:0]    preLast;
  logic [CNT_W-1:0]    cntQ;
  logic                tick;

  // divide by 2^(sel+1): the last prescaler value is sel+1 ones
  always_comb begin
    preLast = PRE_ONES >> (TOP_SEL - selQ);
    tick    = strb.run && (preQ == preLast);
    ovf     = tick && (&cntQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
      preQ <= '0;
      cntQ <= '0;
    end else if (strb.clear) begin
      selQ <= strb.sel;
      preQ <= '0;
      cntQ <= '0;
    end else if (strb.run) begin
      if (tick) begin
        preQ <= '0;
        cntQ <= cntQ + 1'b1;
      end else begin
        preQ <= preQ + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
  import pwrdn_pkg::*;
#(
  parameter int IRQ_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sleepReq,
  input  logic                stbyEnA,
  input  logic                stbyEnB,
  input  logic                busHeldN,
  input  logic                dmaBusy,
  input  logic [IRQ_W-1:0]    wakeIrq,
  input  logic [PD_SEL_W-1:0] clkSel,
  input  logic                ovf,
  output pdStrobe_t           strb,
  output pdMode_e             modeQ,
  output logic                cpuClkEnQ,
  output logic                perClkEnQ,
  output logic                rstPulseQ,
  output logic                refusedQ
);
  pdMode_e modeD;
  logic    wakeAny;
  logic    stbyAllowed;
  logic    stbyAsked;
  logic    enterStby;
  logic    refuseNow;

  always_comb begin
    wakeAny     = |wakeIrq;
    stbyAsked   = stbyEnA && stbyEnB;
    stbyAllowed = busHeldN && !dmaBusy;
    enterStby   = 1'b0;
    refuseNow   = 1'b0;
    modeD       = modeQ;
    unique case (modeQ)
      MODE_RUN: begin
        if (sleepReq) begin
          if (!stbyAsked) begin
            modeD = MODE_SLEEP;
          end else if (stbyAllowed) begin
            modeD     = MODE_STBY;
            enterStby = 1'b1;
          end else begin
            refuseNow = 1'b1;
          end
        end
      end
      MODE_SLEEP:  if (wakeAny) modeD = MODE_RUN;
      MODE_STBY:   if (wakeAny) modeD = MODE_SETTLE;
      MODE_SETTLE: if (ovf)     modeD = MODE_RUN;
      default:     modeD = MODE_RUN;
    endcase
  end

  // strobes to the datapath: zero on standby entry, rearm on wake
  always_comb begin
    strb.clear = enterStby || (modeQ == MODE_STBY && wakeAny);
    strb.run   = (modeQ == MODE_SETTLE);
    strb.sel   = clkSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_RUN;
      cpuClkEnQ <= 1'b1;
      perClkEnQ <= 1'b1;
      rstPulseQ <= 1'b0;
      refusedQ  <= 1'b0;
    end else begin
      modeQ     <= modeD;
      cpuClkEnQ <= (modeD == MODE_RUN);
      perClkEnQ <= (modeD == MODE_RUN) || (modeD == MODE_SLEEP);
      rstPulseQ <= enterStby;
      refusedQ  <= refuseNow;
    end
  end
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int IRQ_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic             stbyEnA,
  input  logic             stbyEnB,
  input  logic             busHeldN,
  input  logic             dmaBusy,
  input  logic [IRQ_W-1:0] wakeIrq,
  input  logic [2:0]       clkSel,
  output logic             cpuClkEn,
  output logic             perClkEn,
  output logic             perRstPulse,
  output logic             refused,
  output logic [1:0]       mode
);
  pdStrobe_t strb;
  pdMode_e   modeQ;
  logic      ovf;

  pwrdn_fsm #(.IRQ_W(IRQ_W)) u_fsm (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq),
    .stbyEnA(stbyEnA), .stbyEnB(stbyEnB),
    .busHeldN(busHeldN), .dmaBusy(dmaBusy),
    .wakeIrq(wakeIrq), .clkSel(clkSel), .ovf(ovf),
    .strb(strb), .modeQ(modeQ),
    .cpuClkEnQ(cpuClkEn), .perClkEnQ(perClkEn),
    .rstPulseQ(perRstPulse), .refusedQ(refused)
  );

  pwrdn_settle #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rstN(rstN), .strb(strb), .ovf(ovf)
  );

  assign mode = modeQ;
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cpuClkEn,
  input logic       perClkEn,
  input logic       perRstPulse,
  input logic       refused,
  input logic [1:0] mode
);
  a_r5_stby_clocks_off: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2) |-> (!cpuClkEn && !perClkEn));

  a_r2_sleep_cpu_only: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1) |-> (!cpuClkEn && perClkEn));

  a_r7_settle_clocks_off: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3) |-> (!cpuClkEn && !perClkEn));

  a_r9_run_clocks_on: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0) |-> (cpuClkEn && perClkEn));

  a_r6_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    perRstPulse |=> !perRstPulse);

  a_r6_pulse_on_entry: assert property (@(posedge clk) disable iff (!rstN)
    perRstPulse |-> (mode == 2'd2 && $past(mode) == 2'd0));

  a_r3_refuse_in_run: assert property (@(posedge clk) disable iff (!rstN)
    refused |-> (mode == 2'd0 && !perRstPulse));

  a_r8_stby_exit_path: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2) |=> (mode == 2'd2 || mode == 2'd3));
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuClkEn(cpuClkEn), .perClkEn(perClkEn),
  .perRstPulse(perRstPulse), .refused(refused), .mode(mode)
);

// File: tb/pwrdn_ctrl_bench.sv
`timescale 1ns/100ps
module pwrdn_ctrl_bench;
  localparam int IRQ_W = 4;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             sleepReq = 1'b0;
  logic             stbyEnA = 1'b0;
  logic             stbyEnB = 1'b0;
  logic             busHeldN = 1'b1;
  logic             dmaBusy = 1'b0;
  logic [IRQ_W-1:0] wakeIrq = '0;
  logic [2:0]       clkSel = 3'd0;
  logic             cpuClkEn, perClkEn, perRstPulse, refused;
  logic [1:0]       mode;

  int total = 0;
  int bad = 0;
  string curReq = "R10";

  // behavioural reference
  int mMode = 0;
  int mRst = 0;
  int mRef = 0;
  int settleLeft = 0;

  always #2.5 clk = ~clk;

  pwrdn_ctrl #(.IRQ_W(IRQ_W), .CNT_W(CNT_W)) u_pwrdn_ctrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq),
    .stbyEnA(stbyEnA), .stbyEnB(stbyEnB), .busHeldN(busHeldN),
    .dmaBusy(dmaBusy), .wakeIrq(wakeIrq), .clkSel(clkSel),
    .cpuClkEn(cpuClkEn), .perClkEn(perClkEn), .perRstPulse(perRstPulse),
    .refused(refused), .mode(mode)
  );

  always @(posedge clk) begin
    mRst = 0;
    mRef = 0;
    if (!rstN) begin
      mMode = 0;
    end else begin
      case (mMode)
        0: if (sleepReq) begin
             if (!(stbyEnA && stbyEnB)) mMode = 1;
             else if (!busHeldN || dmaBusy) mRef = 1;
             else begin mMode = 2; mRst = 1; end
           end
        1: if (wakeIrq != 0) mMode = 0;
        2: if (wakeIrq != 0) begin
             mMode = 3;
             settleLeft = (2 ** (int'(clkSel) + 1)) * (2 ** CNT_W);
           end
        default: begin
          settleLeft = settleLeft - 1;
          if (settleLeft == 0) mMode = 0;
        end
      endcase
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk("mode", int'(mode), mMode);
      chk("cpuClkEn", int'(cpuClkEn), (mMode == 0) ? 1 : 0);
      chk("perClkEn", int'(perClkEn), (mMode <= 1) ? 1 : 0);
      chk("perRstPulse", int'(perRstPulse), mRst);
      chk("refused", int'(refused), mRef);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) sleepReq = 1'b1;
    @(negedge clk) sleepReq = 1'b0;
  endtask

  task automatic wake(input logic [IRQ_W-1:0] v);
    @(negedge clk) wakeIrq = v;
    @(negedge clk) wakeIrq = '0;
  endtask

  task automatic fullStandby(input logic [2:0] sel);
    stbyEnA = 1'b1; stbyEnB = 1'b1; busHeldN = 1'b1; dmaBusy = 1'b0;
    curReq = "R1"; strobe();
    curReq = "R6"; idle(3);
    curReq = "R8"; strobe(); idle(2);
    curReq = "R7"; clkSel = sel; wake(4'b0100);
    clkSel = 3'd0;
    curReq = "R8"; wake(4'b0001);
    curReq = "R7";
    idle((2 ** (int'(sel) + 1)) * (2 ** CNT_W) + 4);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rstN = 1'b1;
    curReq = "R10";
    chk("reset mode", int'(mode), 0);
    chk("reset cpuClkEn", int'(cpuClkEn), 1);
    chk("reset perClkEn", int'(perClkEn), 1);
    chk("reset pulse", int'(perRstPulse) + int'(refused), 0);
    idle(2);

    curReq = "R8"; wake(4'b1111); idle(2);

    // light sleep, first enable clear, bus released and DMA busy
    curReq = "R2"; stbyEnA = 1'b0; stbyEnB = 1'b1; busHeldN = 1'b0; dmaBusy = 1'b1;
    strobe(); idle(3);
    curReq = "R8"; strobe(); idle(2);
    curReq = "R2"; wake(4'b1000); idle(2);
    // second enable clear
    stbyEnA = 1'b1; stbyEnB = 1'b0; busHeldN = 1'b1; dmaBusy = 1'b0;
    strobe(); idle(2); wake(4'b0010); idle(2);

    curReq = "R3"; stbyEnB = 1'b1; busHeldN = 1'b0;
    strobe(); idle(3);
    curReq = "R4"; busHeldN = 1'b1; dmaBusy = 1'b1;
    strobe(); idle(3);
    dmaBusy = 1'b0;

    curReq = "R5"; fullStandby(3'd0);
    curReq = "R9"; idle(2);
    fullStandby(3'd3);
    fullStandby(3'd7);
    curReq = "R9"; idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog %s: actual=hung expected=done", curReq);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule